// File: doc/BRIEF.md
# Stable Marked-Entry Partitioner

This block takes an array of N data words, each tagged with a one-bit mark, and produces a permuted copy. In the copy, every marked word comes first and every unmarked word follows. Within each group, words keep the order they had in the input. The block also reports how many words were marked.

Each word's slot is found without any swapping. Two running counts are formed at the same time: one over the mark bits and one over their complements. A marked word lands at its running marked count minus one. An unmarked word lands after all the marked words, at the total marked count plus its running unmarked count minus one. A scatter stage then moves every word to its slot, and no two words share a slot.

The block is used as a parallel load with a start strobe, followed by a parallel result that is qualified by a one-cycle done pulse. Slot i of every array port sits in bits [i*W +: W] of the data vector and in bit i of the mark vector. Slot 0 is the front of the array.

Top module: `mark_packer`

## Requirements
- R1: Marked input words appear in output slots 0 to count-1 in their original relative order (lower input slot goes to lower output slot).
- R2: Unmarked input words appear in output slots count to N-1 in their original relative order.
- R3: `mark_count` equals the number of set bits in the loaded `in_mark`. It is clog2(N)+1 bits wide and can therefore hold N.
- R4: Bit k of `out_mark` is 1 exactly when k < `mark_count`. It carries the mark of the word that was placed in slot k.
- R5: When all words are marked, or none are, `out_data` equals the loaded `in_data` slot for slot.
- R6: A start is sampled on a rising edge while the block is idle. `done` rises at the second rising edge after that sampling edge, stays high for exactly one cycle, and the results are valid while `done` is high.
- R7: A start that is raised while a result is still being computed is ignored: it neither alters that result nor produces an extra done pulse.
- R8: After `done`, the values on `out_data`, `out_mark` and `mark_count` hold, whatever the inputs do, until the next accepted start completes.
- R9: During and after reset, `done`, `out_data`, `out_mark` and `mark_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe; the inputs are captured when the block is idle |
| in_data | input | N*W | Input words, slot i at bits [i*W +: W] |
| in_mark | input | N | Mark bit for each input slot |
| done | output | 1 | One-cycle pulse that marks the result as valid |
| out_data | output | N*W | Partitioned words |
| out_mark | output | N | Marks of the partitioned words |
| mark_count | output | clog2(N)+1 | Number of marked words |

## Verification
The partition is exercised with random words under random mark vectors, and each result is compared with a bench model that walks the input twice. Directed cases separate the failure modes. All-marked and all-unmarked vectors show whether the unmarked offset is applied. A single mark at either end catches off-by-one errors in the destination indices. Alternating marks reveal any loss of order inside either group. A start raised mid-computation, and inputs that change after done, show whether the result is isolated from later activity.

// File: rtl/mark_packer_pkg.sv
package mark_packer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_MOVE  = 2'd2,
    ST_DONE  = 2'd3
  } pk_state_e;
endpackage

// File: rtl/pk_prefix_count.sv
// Log-step inclusive running count of a flag vector.
module pk_prefix_count #(
  parameter int N  = 8,
  parameter int CW = $clog2(N) + 1
) (
  input  logic [N-1:0]    flags,
  output logic [N*CW-1:0] sums
);
  localparam int LG = $clog2(N);

  logic [CW-1:0] lvl [LG+1][N];

  genvar i, j;
  generate
    for (i = 0; i < N; i++) begin : g_init
      assign lvl[0][i] = CW'(flags[i]);
    end
    for (j = 0; j < LG; j++) begin : g_step
      localparam int D = 1 << j;
      for (i = 0; i < N; i++) begin : g_lane
        if (i >= D) begin : g_add
          assign lvl[j+1][i] = lvl[j][i] + lvl[j][i-D];
        end else begin : g_pass
          assign lvl[j+1][i] = lvl[j][i];
        end
      end
    end
    for (i = 0; i < N; i++) begin : g_out
      assign sums[i*CW +: CW] = lvl[LG][i];
    end
  endgenerate
endmodule

// File: rtl/pk_scatter.sv
// Moves every word to its destination slot; destinations are a permutation.
module pk_scatter #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N*W-1:0]  src_data,
  input  logic [N-1:0]    src_mark,
  input  logic [N*IW-1:0] dest,
  output logic [N*W-1:0]  dst_data,
  output logic [N-1:0]    dst_mark
);
  always_comb begin
    dst_data = '0;
    dst_mark = '0;
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin
        if (dest[i*IW +: IW] == IW'(k)) begin
          dst_data[k*W +: W] = dst_data[k*W +: W] | src_data[i*W +: W];
          dst_mark[k]        = dst_mark[k] | src_mark[i];
        end
      end
    end
  end
endmodule

// File: rtl/mark_packer.sv
module mark_packer
  import mark_packer_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int CW = $clog2(N) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] in_data,
  input  logic [N-1:0]   in_mark,
  output logic           done,
  output logic [N*W-1:0] out_data,
  output logic [N-1:0]   out_mark,
  output logic [CW-1:0]  mark_count
);
  localparam int IW = $clog2(N);

  pk_state_e state_q, state_d;
  logic load_en, count_en, move_en;

  logic [N*W-1:0]  data_q;
  logic [N-1:0]    mark_q;
  logic [N*CW-1:0] pfx_mark, pfx_clear;
  logic [N*IW-1:0] dest_d, dest_q;
  logic [CW-1:0]   total_d, total_q;
  logic [N*W-1:0]  moved_data;
  logic [N-1:0]    moved_mark;

  // control: next state
  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    count_en = 1'b0;
    move_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start) begin load_en = 1'b1; state_d = ST_COUNT; end
      ST_COUNT: begin count_en = 1'b1; state_d = ST_MOVE; end
      ST_MOVE:  begin move_en  = 1'b1; state_d = ST_DONE; end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // input capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mark_q <= '0;
    end else if (load_en) begin
      data_q <= in_data;
      mark_q <= in_mark;
    end
  end

  // both running counts in parallel
  pk_prefix_count #(.N(N), .CW(CW)) u_pfx_mark (
    .flags(mark_q), .sums(pfx_mark)
  );
  pk_prefix_count #(.N(N), .CW(CW)) u_pfx_clear (
    .flags(~mark_q), .sums(pfx_clear)
  );

  // 0-based destinations
  assign total_d = pfx_mark[(N-1)*CW +: CW];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (mark_q[i])
        dest_d[i*IW +: IW] = IW'(pfx_mark[i*CW +: CW] - CW'(1));
      else
        dest_d[i*IW +: IW] = IW'(total_d + pfx_clear[i*CW +: CW] - CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q  <= '0;
      total_q <= '0;
    end else if (count_en) begin
      dest_q  <= dest_d;
      total_q <= total_d;
    end
  end

  pk_scatter #(.N(N), .W(W), .IW(IW)) u_scatter (
    .src_data(data_q), .src_mark(mark_q), .dest(dest_q),
    .dst_data(moved_data), .dst_mark(moved_mark)
  );

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data   <= '0;
      out_mark   <= '0;
      mark_count <= '0;
    end else if (move_en) begin
      out_data   <= moved_data;
      out_mark   <= moved_mark;
      mark_count <= total_q;
    end
  end

  assign done = (state_q == ST_DONE);
endmodule

// File: rtl/mark_packer_checker.sv
module mark_packer_checker #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int CW = $clog2(N) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic [N*W-1:0] out_data,
  input logic [N-1:0]   out_mark,
  input logic [CW-1:0]  mark_count
);
  // R6: single-cycle done pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: count never exceeds the array size
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mark_count <= CW'(N)));

  // R4: marks in the result agree with the reported count
  a_r4_mark_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(out_mark) == int'(mark_count)));

  // R1: marked words form a contiguous front block
  a_r1_front_block: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((out_mark & (out_mark + N'(1))) == '0));

  // R8: results hold after the done pulse
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(out_data) && $stable(out_mark) && $stable(mark_count)));
endmodule

bind mark_packer mark_packer_checker #(.N(N), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .out_data(out_data),
  .out_mark(out_mark), .mark_count(mark_count)
);

// File: tb/mark_packer_test.sv
`timescale 1ns/1ps
module mark_packer_test;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int CW = $clog2(N) + 1;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [N*W-1:0] in_data;
  logic [N-1:0]   in_mark;
  logic           done;
  logic [N*W-1:0] out_data;
  logic [N-1:0]   out_mark;
  logic [CW-1:0]  mark_count;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  mark_packer #(.N(N), .W(W), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
    .in_mark(in_mark), .done(done), .out_data(out_data),
    .out_mark(out_mark), .mark_count(mark_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] model_data(input logic [N*W-1:0] d,
                                                input logic [N-1:0] m);
    logic [N*W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < N; i++)
      if (m[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
    for (int i = 0; i < N; i++)
      if (!m[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
    return r;
  endfunction

  function automatic int model_count(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [N-1:0] model_marks(input int c);
    logic [N-1:0] r = '0;
    for (int k = 0; k < N; k++) r[k] = (k < c);
    return r;
  endfunction

  // disturb: raise start with other data while busy (R7)
  task automatic run(input logic [N*W-1:0] d, input logic [N-1:0] m,
                     input bit disturb, input string tag);
    int c;
    @(negedge clk);
    in_data = d; in_mark = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (disturb) begin
      in_data = ~d; in_mark = ~m; start = 1'b1;
    end else begin
      start = 1'b0;
    end
    chk(done == 1'b0, "R6 no done one edge after start", 64'(done), 64'd0);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6 no done two edges after start", 64'(done), 64'd0);
    @(negedge clk);
    chk(done == 1'b1, "R6 done at expected edge", 64'(done), 64'd1);
    c = model_count(m);
    chk(out_data == model_data(d, m), {"R1 R2 order ", tag},
        64'(out_data), 64'(model_data(d, m)));
    chk(int'(mark_count) == c, {"R3 count ", tag}, 64'(mark_count), 64'(c));
    chk(out_mark == model_marks(c), {"R4 marks ", tag},
        64'(out_mark), 64'(model_marks(c)));
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    logic [N*W-1:0] d;
    logic [N*W-1:0] held;
    start = 1'b0; in_data = '0; in_mark = '0; rst_n = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && out_data == '0 && out_mark == '0 && mark_count == '0,
        "R9 reset state", 64'(out_data), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && out_data == '0, "R9 idle after reset",
        64'(done), 64'd0);

    d = {$urandom, $urandom};
    run(d, '1, 1'b0, "all marked");
    chk(out_data == d, "R5 all marked keeps input", 64'(out_data), 64'(d));
    d = {$urandom, $urandom};
    run(d, '0, 1'b0, "none marked");
    chk(out_data == d, "R5 none marked keeps input", 64'(out_data), 64'(d));
    run({$urandom, $urandom}, 8'b1000_0000, 1'b0, "last only");
    run({$urandom, $urandom}, 8'b0000_0001, 1'b0, "first only");
    run({$urandom, $urandom}, 8'b0101_0101, 1'b0, "alternating");
    run({$urandom, $urandom}, 8'b1111_0000, 1'b0, "upper half");

    // R7: start during computation is ignored
    d = {$urandom, $urandom};
    run(d, 8'b0011_0110, 1'b1, "R7 disturbed");
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 no extra done", 64'(done), 64'd0);
    end

    // R8: results hold while inputs move
    held = out_data;
    repeat (5) begin
      @(negedge clk);
      in_data = {$urandom, $urandom}; in_mark = N'($urandom);
      chk(out_data == held, "R8 result holds", 64'(out_data), 64'(held));
    end

    for (int t = 0; t < 200; t++)
      run({$urandom, $urandom}, N'($urandom), 1'b0, "random");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule